// File: doc/BRIEF.md
# Alamouti space-time block combiner

This block sits after OFDM demodulation and channel estimation in a receiver that uses a two-transmit-antenna Alamouti code. Subcarrier samples stream in one per valid cycle. Each sample carries the received value from every receive antenna, together with the gain estimates for both transmit paths into each of those antennas. Every code block covers the same subcarrier in two consecutive OFDM symbols. For that reason the block holds one full symbol of received data per receive antenna in a shift-register line. When the sample of the next symbol arrives on the same subcarrier, the block pairs it with the stored one.

For each subcarrier of the second symbol the block emits two soft symbol estimates. It forms them by purely linear conjugate-multiply-and-add combining, which cancels the interference between the two transmit antennas. The per-antenna arithmetic is replicated once per receive antenna, and the copies are summed. Products are truncated to an intermediate width. The sums are scaled down and saturated to the output width. A symbol-start flag realigns the pairing, so the symbol that begins with it is always the first half of a block.

Top module: `alam_combiner`

## Requirements
- R1: After reset, `out_valid` is 0 and all four estimate outputs are 0.
- R2: A sample that falls in the first symbol of a pair produces no output (`out_valid` stays 0 in the following cycle). Each second-symbol sample produces `out_valid`=1 exactly one clock cycle after it is accepted.
- R3: Estimate 1 equals the sum over receive antennas j of conj(h1j)·r1 + h2j·conj(r2). Here r1 is the first-symbol sample, r2 is the second-symbol sample, and h1j and h2j are the gains presented with the second symbol.
- R4: Estimate 2 equals the sum over j of conj(h2j)·r1 − h1j·conj(r2), with the same operands as R3.
- R5: Second-symbol subcarrier k is paired with first-symbol subcarrier k. A symbol is NSC accepted samples long, and the two halves alternate.
- R6: An accepted sample with `in_sos`=1 is subcarrier 0 of a first-half symbol, whatever the pairing state was before it. It produces no output.
- R7: After scaling, each estimate component is saturated to the signed range of OUT_W bits. The default range is −256..255.
- R8: Each real component of each conjugate product is arithmetically shifted right by PROD_SHIFT (floor) before summation. The final sum is shifted right by OUT_SHIFT (floor) before saturation.
- R9: The contributions of all NRX receive antennas are added into each estimate.
- R10: Cycles with `in_valid`=0 change no pairing state or stored samples, and they give `out_valid`=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample accepted this cycle |
| in_sos | input | 1 | Sample is subcarrier 0 of a new first-half symbol |
| in_r_re | input | NRX*IN_W | Received real parts, antenna j at bits j*IN_W |
| in_r_im | input | NRX*IN_W | Received imaginary parts |
| in_h1_re | input | NRX*IN_W | Gain from transmit antenna 1, real |
| in_h1_im | input | NRX*IN_W | Gain from transmit antenna 1, imaginary |
| in_h2_re | input | NRX*IN_W | Gain from transmit antenna 2, real |
| in_h2_im | input | NRX*IN_W | Gain from transmit antenna 2, imaginary |
| out_valid | output | 1 | Estimate pair valid |
| out_s1_re | output | OUT_W | Estimate 1, real |
| out_s1_im | output | OUT_W | Estimate 1, imaginary |
| out_s2_re | output | OUT_W | Estimate 2, real |
| out_s2_im | output | OUT_W | Estimate 2, imaginary |

## Verification
The main vector table pairs symbols with different patterns on each subcarrier. One row has a single small negative product, which separates floor truncation from rounding toward zero. Rows with mixed signs on both antennas expose any swapped conjugate or wrong add/subtract sign. A row that drives one antenna with zeros shows whether each antenna's terms are summed or dropped. Full-scale rows push both estimates into saturation. Junk gains driven during first symbols confirm that only the second symbol's gains are used. Directed runs insert idle gaps inside a block and restart the pairing mid-symbol with the start flag. Both runs check that the pairing stays aligned by subcarrier.

// File: rtl/alam_pkg.sv
package alam_pkg;
    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;
endpackage

// File: rtl/alam_ctrl.sv
module alam_ctrl
    import alam_pkg::*;
#(
    parameter int NSC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sos,
    output logic pair_second
);
    localparam int CW = (NSC > 1) ? $clog2(NSC) : 1;
    localparam logic [CW-1:0] LAST = CW'(NSC - 1);

    typedef struct packed {
        phase_e          ph;
        logic [CW-1:0]   cnt;
    } st_t;

    st_t st_d, st_q;
    phase_e cur_ph;
    logic [CW-1:0] cur_cnt;

    always_comb begin
        st_d    = st_q;
        cur_ph  = in_sos ? PH_FIRST : st_q.ph;
        cur_cnt = in_sos ? '0 : st_q.cnt;
        if (in_valid) begin
            if (cur_cnt == LAST) begin
                st_d.cnt = '0;
                st_d.ph  = (cur_ph == PH_FIRST) ? PH_SECOND : PH_FIRST;
            end else begin
                st_d.cnt = cur_cnt + 1'b1;
                st_d.ph  = cur_ph;
            end
        end
        pair_second = in_valid && (cur_ph == PH_SECOND);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_FIRST, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q)); // R10
endmodule

// File: rtl/alam_delay.sv
module alam_delay #(
    parameter int NRX  = 2,
    parameter int IN_W = 8,
    parameter int NSC  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift,
    input  logic [NRX*IN_W-1:0] din_re,
    input  logic [NRX*IN_W-1:0] din_im,
    output logic [NRX*IN_W-1:0] dout_re,
    output logic [NRX*IN_W-1:0] dout_im
);
    for (genvar j = 0; j < NRX; j++) begin : g_ant
        typedef struct packed {
            logic [NSC-1:0][IN_W-1:0] re;
            logic [NSC-1:0][IN_W-1:0] im;
        } line_t;

        line_t line_d, line_q;

        always_comb begin
            line_d = line_q;
            if (shift) begin
                line_d.re = {line_q.re[NSC-2:0], din_re[j*IN_W +: IN_W]};
                line_d.im = {line_q.im[NSC-2:0], din_im[j*IN_W +: IN_W]};
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                line_q <= '0;
            end else begin
                line_q <= line_d;
            end
        end

        assign dout_re[j*IN_W +: IN_W] = line_q.re[NSC-1];
        assign dout_im[j*IN_W +: IN_W] = line_q.im[NSC-1];
    end

    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> ($stable(dout_re) && $stable(dout_im))); // R10
endmodule

// File: rtl/alam_cmul.sv
module alam_cmul #(
    parameter int IN_W       = 8,
    parameter int MID_W      = 14,
    parameter int PROD_SHIFT = 3
) (
    input  logic signed [IN_W-1:0]  h_re,
    input  logic signed [IN_W-1:0]  h_im,
    input  logic signed [IN_W-1:0]  r_re,
    input  logic signed [IN_W-1:0]  r_im,
    output logic signed [MID_W-1:0] p_re,
    output logic signed [MID_W-1:0] p_im
);
    localparam int PW = 2 * IN_W + 1;

    logic signed [PW-1:0] f_re, f_im;

    // conj(h) * r
    assign f_re = PW'(h_re) * PW'(r_re) + PW'(h_im) * PW'(r_im);
    assign f_im = PW'(h_re) * PW'(r_im) - PW'(h_im) * PW'(r_re);
    assign p_re = MID_W'(f_re >>> PROD_SHIFT);
    assign p_im = MID_W'(f_im >>> PROD_SHIFT);
endmodule

// File: rtl/alam_combiner.sv
module alam_combiner #(
    parameter int NRX        = 2,
    parameter int NSC        = 8,
    parameter int IN_W       = 8,
    parameter int MID_W      = 14,
    parameter int PROD_SHIFT = 3,
    parameter int OUT_SHIFT  = 2,
    parameter int OUT_W      = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_sos,
    input  logic [NRX*IN_W-1:0] in_r_re,
    input  logic [NRX*IN_W-1:0] in_r_im,
    input  logic [NRX*IN_W-1:0] in_h1_re,
    input  logic [NRX*IN_W-1:0] in_h1_im,
    input  logic [NRX*IN_W-1:0] in_h2_re,
    input  logic [NRX*IN_W-1:0] in_h2_im,
    output logic                out_valid,
    output logic [OUT_W-1:0]    out_s1_re,
    output logic [OUT_W-1:0]    out_s1_im,
    output logic [OUT_W-1:0]    out_s2_re,
    output logic [OUT_W-1:0]    out_s2_im
);
    localparam int VW    = NRX * IN_W;
    localparam int ACC_W = MID_W + $clog2(NRX) + 2;
    localparam logic signed [ACC_W-1:0] SMAX = ACC_W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] SMIN = -SMAX - 1;

    typedef struct packed {
        logic                    valid;
        logic signed [OUT_W-1:0] s1_re;
        logic signed [OUT_W-1:0] s1_im;
        logic signed [OUT_W-1:0] s2_re;
        logic signed [OUT_W-1:0] s2_im;
    } out_t;

    logic          pair_second;
    logic [VW-1:0] old_re, old_im;

    logic signed [MID_W-1:0] p11_re [NRX];
    logic signed [MID_W-1:0] p11_im [NRX];
    logic signed [MID_W-1:0] p21_re [NRX];
    logic signed [MID_W-1:0] p21_im [NRX];
    logic signed [MID_W-1:0] p22_re [NRX];
    logic signed [MID_W-1:0] p22_im [NRX];
    logic signed [MID_W-1:0] p12_re [NRX];
    logic signed [MID_W-1:0] p12_im [NRX];

    alam_ctrl #(.NSC(NSC)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_sos      (in_sos),
        .pair_second (pair_second)
    );

    alam_delay #(.NRX(NRX), .IN_W(IN_W), .NSC(NSC)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift   (in_valid),
        .din_re  (in_r_re),
        .din_im  (in_r_im),
        .dout_re (old_re),
        .dout_im (old_im)
    );

    for (genvar j = 0; j < NRX; j++) begin : g_rx
        logic signed [IN_W-1:0] r1_re, r1_im, r2_re, r2_im;
        logic signed [IN_W-1:0] h1_re, h1_im, h2_re, h2_im;
        assign r1_re = old_re[j*IN_W +: IN_W];
        assign r1_im = old_im[j*IN_W +: IN_W];
        assign r2_re = in_r_re[j*IN_W +: IN_W];
        assign r2_im = in_r_im[j*IN_W +: IN_W];
        assign h1_re = in_h1_re[j*IN_W +: IN_W];
        assign h1_im = in_h1_im[j*IN_W +: IN_W];
        assign h2_re = in_h2_re[j*IN_W +: IN_W];
        assign h2_im = in_h2_im[j*IN_W +: IN_W];

        alam_cmul #(.IN_W(IN_W), .MID_W(MID_W), .PROD_SHIFT(PROD_SHIFT)) u_p11 (
            .h_re(h1_re), .h_im(h1_im), .r_re(r1_re), .r_im(r1_im),
            .p_re(p11_re[j]), .p_im(p11_im[j]));
        alam_cmul #(.IN_W(IN_W), .MID_W(MID_W), .PROD_SHIFT(PROD_SHIFT)) u_p21 (
            .h_re(h2_re), .h_im(h2_im), .r_re(r1_re), .r_im(r1_im),
            .p_re(p21_re[j]), .p_im(p21_im[j]));
        alam_cmul #(.IN_W(IN_W), .MID_W(MID_W), .PROD_SHIFT(PROD_SHIFT)) u_p22 (
            .h_re(h2_re), .h_im(h2_im), .r_re(r2_re), .r_im(r2_im),
            .p_re(p22_re[j]), .p_im(p22_im[j]));
        alam_cmul #(.IN_W(IN_W), .MID_W(MID_W), .PROD_SHIFT(PROD_SHIFT)) u_p12 (
            .h_re(h1_re), .h_im(h1_im), .r_re(r2_re), .r_im(r2_im),
            .p_re(p12_re[j]), .p_im(p12_im[j]));
    end

    function automatic logic signed [OUT_W-1:0] sat(input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] s;
        s = v >>> OUT_SHIFT;
        if (s > SMAX) begin
            s = SMAX;
        end else if (s < SMIN) begin
            s = SMIN;
        end
        return OUT_W'(s);
    endfunction

    // Add/subtract select: sub=1 subtracts the second-symbol term.
    function automatic logic signed [ACC_W-1:0] addsub(
        input logic signed [ACC_W-1:0] acc,
        input logic signed [MID_W-1:0] a,
        input logic signed [MID_W-1:0] b,
        input logic                    sub
    );
        return sub ? (acc + ACC_W'(a) - ACC_W'(b)) : (acc + ACC_W'(a) + ACC_W'(b));
    endfunction

    out_t out_d, out_q;
    logic signed [ACC_W-1:0] a1_re, a1_im, a2_re, a2_im;

    always_comb begin
        a1_re = '0;
        a1_im = '0;
        a2_re = '0;
        a2_im = '0;
        for (int j = 0; j < NRX; j++) begin
            // s1 = P11 + conj(P22); s2 = P21 - conj(P12)
            a1_re = addsub(a1_re, p11_re[j], p22_re[j], 1'b0);
            a1_im = addsub(a1_im, p11_im[j], p22_im[j], 1'b1);
            a2_re = addsub(a2_re, p21_re[j], p12_re[j], 1'b1);
            a2_im = addsub(a2_im, p21_im[j], p12_im[j], 1'b0);
        end
        out_d       = out_q;
        out_d.valid = pair_second;
        if (pair_second) begin
            out_d.s1_re = sat(a1_re);
            out_d.s1_im = sat(a1_im);
            out_d.s2_re = sat(a2_re);
            out_d.s2_im = sat(a2_im);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.valid;
    assign out_s1_re = out_q.s1_re;
    assign out_s1_im = out_q.s1_im;
    assign out_s2_re = out_q.s2_re;
    assign out_s2_im = out_q.s2_im;

    AST_OUT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R2
    AST_SOS_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sos) |=> !out_valid); // R6
    AST_IDLE_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R10
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_s1_re)); // R2
endmodule

// File: tb/alam_combiner_tb.sv
`timescale 1ns/1ps
module alam_combiner_tb_top;
    localparam int NRX = 2, NSC = 4, IN_W = 8, MID_W = 14;
    localparam int PS = 3, OS = 2, OUT_W = 9;
    localparam int VW = NRX * IN_W;
    localparam int NROW = 8;

    // Per antenna: r1re r1im r2re r2im h1re h1im h2re h2im
    localparam int TV [NROW][16] = '{
        '{ -3,   0,   0,   0,   1,   0,   0,   0,     0,   0,   0,   0,   0,   0,   0,   0},
        '{ 10,  -5,   7,   3,  20,   4,  -6,   9,   -12,   8,   4,  -9,   3, -15,  11,   2},
        '{ 50,  60, -40,  30, -25,  70,  33, -18,     5,  -7,  90, -60,  41,  12, -80,  27},
        '{100,-100, -90,  80,  60, -50, -70,  40,     0,   0,   0,   0,   0,   0,   0,   0},
        '{  1,   2,   3,   4,   5,   6,   7,   8,    -8,  -7,  -6,  -5,  -4,  -3,  -2,  -1},
        '{127, 127,-128,-128, 127,-128,-128, 127,   127, 127,-128,-128, 127,-128,-128, 127},
        '{-60,  25,  17, -99,  44, -13, -70,  55,    31, -64, -22,  48, -90,  66,   9, -37},
        '{-128,-128,-128,-128,-128,-128,-128,-128, -128,-128,-128,-128,-128,-128,-128,-128}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sos = 1'b0;
    logic [VW-1:0] in_r_re = '0, in_r_im = '0;
    logic [VW-1:0] in_h1_re = '0, in_h1_im = '0, in_h2_re = '0, in_h2_im = '0;
    logic out_valid;
    logic [OUT_W-1:0] out_s1_re, out_s1_im, out_s2_re, out_s2_im;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    alam_combiner #(
        .NRX(NRX), .NSC(NSC), .IN_W(IN_W), .MID_W(MID_W),
        .PROD_SHIFT(PS), .OUT_SHIFT(OS), .OUT_W(OUT_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sos(in_sos),
        .in_r_re(in_r_re), .in_r_im(in_r_im),
        .in_h1_re(in_h1_re), .in_h1_im(in_h1_im),
        .in_h2_re(in_h2_re), .in_h2_im(in_h2_im),
        .out_valid(out_valid),
        .out_s1_re(out_s1_re), .out_s1_im(out_s1_im),
        .out_s2_re(out_s2_re), .out_s2_im(out_s2_im)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int tr(input int v);
        return v >>> PS;
    endfunction

    function automatic int sat(input int v);
        int s = v >>> OS;
        int mx = (1 << (OUT_W - 1)) - 1;
        if (s > mx) s = mx;
        if (s < -mx - 1) s = -mx - 1;
        return s;
    endfunction

    // which: 0 s1re, 1 s1im, 2 s2re, 3 s2im; r1 from row a, r2 and h from row b
    function automatic int model(input int a, input int b, input int which);
        int acc = 0;
        for (int j = 0; j < NRX; j++) begin
            int o = j * 8;
            int r1r = TV[a][o], r1i = TV[a][o+1];
            int r2r = TV[b][o+2], r2i = TV[b][o+3];
            int h1r = TV[b][o+4], h1i = TV[b][o+5];
            int h2r = TV[b][o+6], h2i = TV[b][o+7];
            case (which)
                0: acc += tr(h1r*r1r + h1i*r1i) + tr(h2r*r2r + h2i*r2i);
                1: acc += tr(h1r*r1i - h1i*r1r) - tr(h2r*r2i - h2i*r2r);
                2: acc += tr(h2r*r1r + h2i*r1i) - tr(h1r*r2r + h1i*r2i);
                default: acc += tr(h2r*r1i - h2i*r1r) + tr(h1r*r2i - h1i*r2r);
            endcase
        end
        return sat(acc);
    endfunction

    // Drive one accepted sample at the falling edge, then sample after the rising edge.
    task automatic step(input bit v, input bit sos, input int row, input bit second);
        @(negedge clk);
        in_valid = v;
        in_sos = sos;
        for (int j = 0; j < NRX; j++) begin
            int o = j * 8 + (second ? 2 : 0);
            in_r_re[j*IN_W +: IN_W] = IN_W'(TV[row][o]);
            in_r_im[j*IN_W +: IN_W] = IN_W'(TV[row][o+1]);
            in_h1_re[j*IN_W +: IN_W] = second ? IN_W'(TV[row][j*8+4]) : IN_W'(77);
            in_h1_im[j*IN_W +: IN_W] = second ? IN_W'(TV[row][j*8+5]) : IN_W'(-91);
            in_h2_re[j*IN_W +: IN_W] = second ? IN_W'(TV[row][j*8+6]) : IN_W'(53);
            in_h2_im[j*IN_W +: IN_W] = second ? IN_W'(TV[row][j*8+7]) : IN_W'(-33);
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_sos = 1'b0;
    endtask

    task automatic chk_est(input string tag, input int a, input int b);
        chk({tag, " R2 valid"}, int'(out_valid), 1);
        chk({tag, " R3 s1re"}, int'($signed(out_s1_re)), model(a, b, 0));
        chk({tag, " R3 s1im"}, int'($signed(out_s1_im)), model(a, b, 1));
        chk({tag, " R4 s2re"}, int'($signed(out_s2_re)), model(a, b, 2));
        chk({tag, " R4 s2im"}, int'($signed(out_s2_im)), model(a, b, 3));
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 valid", int'(out_valid), 0);
        chk("R1 s1re", int'($signed(out_s1_re)), 0);
        chk("R1 s2im", int'($signed(out_s2_im)), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: two blocks, R5 same-subcarrier pairing, R9 antenna sum
        for (int b = 0; b < NROW / NSC; b++) begin
            for (int k = 0; k < NSC; k++) begin
                step(1'b1, k == 0, b*NSC + k, 1'b0);
                chk("R2 first half quiet", int'(out_valid), 0);
            end
            for (int k = 0; k < NSC; k++) begin
                step(1'b1, 1'b0, b*NSC + k, 1'b1);
                chk_est("R5 table", b*NSC + k, b*NSC + k);
            end
        end

        // R8: row 0 gives -3>>>3 = -1 and then -1>>>2 = -1 (floor, not toward zero)
        for (int k = 0; k < NSC; k++) step(1'b1, k == 0, k, 1'b0);
        step(1'b1, 1'b0, 0, 1'b1);
        chk("R8 floor trunc s1re", int'($signed(out_s1_re)), -1);
        for (int k = 1; k < NSC; k++) step(1'b1, 1'b0, k, 1'b1);

        // R7: row 7 full scale saturates estimate 1 real to +255
        for (int k = 0; k < NSC; k++) step(1'b1, k == 0, 4 + k, 1'b0);
        for (int k = 0; k < NSC; k++) begin
            step(1'b1, 1'b0, 4 + k, 1'b1);
            if (k == 3) chk("R7 saturate s1re", int'($signed(out_s1_re)), 255);
        end

        // R10: idle gaps inside a block keep pairing and state
        for (int k = 0; k < NSC; k++) begin
            step(1'b1, k == 0, 2 + k, 1'b0);
            step(1'b0, 1'b0, 7, 1'b0);
            chk("R10 idle quiet", int'(out_valid), 0);
        end
        for (int k = 0; k < NSC; k++) begin
            step(1'b0, 1'b0, 7, 1'b1);
            chk("R10 idle quiet second", int'(out_valid), 0);
            step(1'b1, 1'b0, 2 + k, 1'b1);
            chk_est("R10 gaps", 2 + k, 2 + k);
        end

        // R6: restart with in_sos in the middle of a second half
        for (int k = 0; k < NSC; k++) step(1'b1, k == 0, k, 1'b0);
        step(1'b1, 1'b0, 0, 1'b1);
        chk_est("R6 before restart", 0, 0);
        step(1'b1, 1'b1, 6, 1'b0);
        chk("R6 sos sample quiet", int'(out_valid), 0);
        for (int k = 1; k < NSC; k++) begin
            step(1'b1, 1'b0, 6 - k + 1 > 7 ? 7 : (k == 1 ? 1 : (k == 2 ? 3 : 5)), 1'b0);
            chk("R6 first half quiet", int'(out_valid), 0);
        end
        step(1'b1, 1'b0, 6, 1'b1);
        chk_est("R6 pair k0", 6, 6);
        step(1'b1, 1'b0, 1, 1'b1);
        chk_est("R6 pair k1", 1, 1);
        step(1'b1, 1'b0, 3, 1'b1);
        chk_est("R6 pair k2", 3, 3);
        step(1'b1, 1'b0, 5, 1'b1);
        chk_est("R6 pair k3", 5, 5);
        step(1'b0, 1'b0, 0, 1'b0);
        chk("R2 back to first half", int'(out_valid), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule